// File: doc/BRIEF.md
# Three-Wire Serial Register Access Port

This block is the slave side of a three-pin serial link: an enable line, a serial clock and a data line. The data line is split into an input, an output and an output-enable. A host raises the enable line and clocks in a command byte, least significant bit first. The command selects one of two address spaces (clock registers or a 31-byte scratch RAM), an address, and a read or write direction. One data byte follows. If the address field is all ones, a burst of data bytes follows instead. On the chip side the block drives a simple register bus with an address, a space select, write data, a one-cycle write strobe, a one-cycle read strobe, and a read-data return that is valid one cycle after the read strobe.

All three pins are brought into the system clock domain through a synchroniser. Every pin action is taken on detected edges of the synchronised serial clock. This requires the serial clock high and low phases to each last several system clocks. A single controller state machine sequences the transfer.

The states are:
- IDLE: the enable line is low.
- CMD: the command bits are being shifted in.
- DECODE: the command is split into its fields.
- WR_BITS: write data bits are being gathered.
- WR_STROBE: the write strobe is raised.
- WR_ADV: the burst address and count are advanced.
- RD_FETCH: the read strobe is raised.
- RD_LOAD: the read data is being returned.
- RD_CAPT: the returned byte is latched.
- RD_BITS: the bits are driven out.
- RD_ADV: the burst address and count are advanced.
- DONE: the transfer is complete and further clocks are ignored.

The transitions are:
- IDLE goes to CMD while the enable line is high.
- CMD goes to DECODE on the eighth rising edge.
- DECODE goes to WR_BITS or to RD_FETCH, chosen by the direction bit.
- WR_BITS goes to WR_STROBE on the eighth rising edge.
- WR_STROBE goes to WR_ADV.
- WR_ADV goes back to WR_BITS while the burst has bytes left, otherwise to DONE.
- RD_FETCH goes to RD_LOAD, then to RD_CAPT, then to RD_BITS.
- RD_BITS goes to RD_ADV on the eighth falling edge.
- RD_ADV goes back to RD_FETCH while the burst has bytes left, otherwise to DONE.
- From any state, the enable line low returns the machine to IDLE.

Top module: `s3w_slave`

## Requirements
- R1: After reset, and whenever the synchronised enable line is low, the block raises neither strobe and holds `dio_oe` low.
- R2: The command byte is taken from `dio_in` on eight rising serial-clock edges, LSB first. Bit 0 set means read and clear means write. Bits 5..1 give the address (bit 1 is the LSB). Bit 6 gives the space, 0 for clock registers and 1 for RAM; it appears on `reg_space`.
- R3: In a single-byte write, exactly one `reg_we` pulse of one cycle is issued. It comes after the eighth data bit is received (LSB first) and carries the command address and the assembled byte. Further clocks in the same transfer issue no strobe.
- R4: When command bit 7 is 0, no `reg_we` is issued for the whole transfer. Reads with bit 7 at 0 still return data.
- R5: A read issues one `reg_re` for the command address. It then drives the byte on `dio_out` LSB first, one bit per falling serial-clock edge, starting with the first falling edge after the command. `dio_oe` goes high at that first falling edge and stays high until the enable line drops.
- R6: Address 31 selects burst mode. The burst starts at address 0 and increments by one per byte. It covers 31 bytes in RAM space and 8 bytes in clock space. A burst write strobes once per byte, and a burst read fetches once per byte. No strobe ever carries address 31.
- R7: Dropping the enable line at any point aborts the transfer. A partial data byte is never written, `dio_oe` falls, and the next transfer starts again with a fresh command byte.
- R8: If the enable line drops in the same synchronised cycle as the rising edge that completes a data byte, the abort wins and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Transfer enable from host, high during a transfer |
| sclk | input | 1 | Serial clock from host |
| dio_in | input | 1 | Serial data from host |
| dio_out | output | 1 | Serial read data to host |
| dio_oe | output | 1 | Drive enable for the data line |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_space | output | 1 | Space select: 0 clock registers, 1 RAM |
| reg_addr | output | 5 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_re` |

## Verification
Two events can reach the controller in the same system clock: the release of the enable line and the serial-clock rising edge that completes a data byte. The abort path and the write strobe path then compete. The bench provokes this by changing both pins on the same clock edge during the eighth data bit of a write. It judges the outcome in two ways: the strobe monitor must see no write, and a later read of that address must return the old contents. A second overlap is exercised by the burst reads, where the last bit of one byte is driven in the same step that starts the fetch of the next byte. Every bit of all 31 RAM bytes is compared.

// File: rtl/s3w_pkg.sv
package s3w_pkg;
    localparam int DW = 8;
    localparam int AW = 5;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_DECODE,
        ST_WR_BITS, ST_WR_STROBE, ST_WR_ADV,
        ST_RD_FETCH, ST_RD_LOAD, ST_RD_CAPT, ST_RD_BITS, ST_RD_ADV,
        ST_DONE
    } ctl_state_t;
endpackage

// File: rtl/s3w_pin_sync.sv
module s3w_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [STAGES-1:0][W-1:0] stage_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            prev_q  <= '0;
        end else begin
            stage_q[0] <= pin_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign lvl_o  = stage_q[STAGES-1];
    assign rise_o = stage_q[STAGES-1] & ~prev_q;
    assign fall_o = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/s3w_ctrl.sv
module s3w_ctrl
    import s3w_pkg::*;
#(
    parameter int CLK_BURST_LEN = 8,
    parameter int RAM_BURST_LEN = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          din_i,
    input  logic [DW-1:0] rdata_i,
    output logic          we_o,
    output logic          re_o,
    output logic          space_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          dout_o,
    output logic          oe_o,
    output logic [DW-1:0] cmd_o
);
    localparam logic [AW-1:0] CLK_LAST   = AW'(CLK_BURST_LEN - 1);
    localparam logic [AW-1:0] RAM_LAST   = AW'(RAM_BURST_LEN - 1);
    localparam logic [AW-1:0] BURST_CODE = '1;

    ctl_state_t    state, st_n;
    logic [2:0]    bit_cnt, bit_n;
    logic [DW-1:0] sh_q, sh_n, cmd_q, cmd_n, wdata_q, wdata_n;
    logic [AW-1:0] addr_q, addr_n, byte_cnt, bytes_n;
    logic          dout_q, dout_n, oe_q, oe_n, we_q, we_n, re_q, re_n;
    logic          burst, more;

    assign burst = (cmd_q[5:1] == BURST_CODE);
    assign more  = burst && (byte_cnt != (cmd_q[6] ? RAM_LAST : CLK_LAST));

    // state and datapath register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            sh_q     <= '0;
            cmd_q    <= '0;
            wdata_q  <= '0;
            addr_q   <= '0;
            byte_cnt <= '0;
            dout_q   <= 1'b0;
            oe_q     <= 1'b0;
            we_q     <= 1'b0;
            re_q     <= 1'b0;
        end else begin
            state    <= st_n;
            bit_cnt  <= bit_n;
            sh_q     <= sh_n;
            cmd_q    <= cmd_n;
            wdata_q  <= wdata_n;
            addr_q   <= addr_n;
            byte_cnt <= bytes_n;
            dout_q   <= dout_n;
            oe_q     <= oe_n;
            we_q     <= we_n;
            re_q     <= re_n;
        end
    end

    // transitions and next outputs
    always_comb begin
        st_n    = state;
        bit_n   = bit_cnt;
        sh_n    = sh_q;
        cmd_n   = cmd_q;
        wdata_n = wdata_q;
        addr_n  = addr_q;
        bytes_n = byte_cnt;
        dout_n  = dout_q;
        oe_n    = oe_q;
        we_n    = 1'b0;
        re_n    = 1'b0;
        if (!ce_i) begin
            st_n  = ST_IDLE;
            bit_n = '0;
            oe_n  = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    st_n  = ST_CMD;
                    bit_n = '0;
                end
                ST_CMD: if (rise_i) begin
                    cmd_n = {din_i, cmd_q[DW-1:1]};
                    bit_n = bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) st_n = ST_DECODE;
                end
                ST_DECODE: begin
                    addr_n  = burst ? '0 : cmd_q[5:1];
                    bytes_n = '0;
                    bit_n   = '0;
                    st_n    = cmd_q[0] ? ST_RD_FETCH : ST_WR_BITS;
                end
                ST_WR_BITS: if (rise_i) begin
                    sh_n  = {din_i, sh_q[DW-1:1]};
                    bit_n = bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) st_n = ST_WR_STROBE;
                end
                ST_WR_STROBE: begin
                    we_n    = cmd_q[7];
                    wdata_n = sh_q;
                    st_n    = ST_WR_ADV;
                end
                ST_WR_ADV: begin
                    if (more) begin
                        addr_n  = addr_q + 1'b1;
                        bytes_n = byte_cnt + 1'b1;
                        st_n    = ST_WR_BITS;
                    end else begin
                        st_n = ST_DONE;
                    end
                end
                ST_RD_FETCH: begin
                    re_n = 1'b1;
                    st_n = ST_RD_LOAD;
                end
                ST_RD_LOAD: st_n = ST_RD_CAPT;
                ST_RD_CAPT: begin
                    sh_n  = rdata_i;
                    bit_n = '0;
                    st_n  = ST_RD_BITS;
                end
                ST_RD_BITS: if (fall_i) begin
                    dout_n = sh_q[0];
                    sh_n   = {1'b0, sh_q[DW-1:1]};
                    oe_n   = 1'b1;
                    bit_n  = bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) st_n = ST_RD_ADV;
                end
                ST_RD_ADV: begin
                    if (more) begin
                        addr_n  = addr_q + 1'b1;
                        bytes_n = byte_cnt + 1'b1;
                        st_n    = ST_RD_FETCH;
                    end else begin
                        st_n = ST_DONE;
                    end
                end
                ST_DONE: st_n = ST_DONE;
                default: st_n = ST_IDLE;
            endcase
        end
    end

    assign we_o    = we_q;
    assign re_o    = re_q;
    assign space_o = cmd_q[6];
    assign addr_o  = addr_q;
    assign wdata_o = wdata_q;
    assign dout_o  = dout_q;
    assign oe_o    = oe_q;
    assign cmd_o   = cmd_q;
endmodule

// File: rtl/s3w_slave.sv
module s3w_slave
    import s3w_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int CLK_BURST_LEN = 8,
    parameter int RAM_BURST_LEN = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          sclk,
    input  logic          dio_in,
    output logic          dio_out,
    output logic          dio_oe,
    output logic          reg_we,
    output logic          reg_re,
    output logic          reg_space,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] pin_lvl, pin_rise, pin_fall;
    logic            ce_s;
    logic [DW-1:0]   cmd_byte;

    s3w_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({ce, sclk, dio_in}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign ce_s = pin_lvl[2];

    s3w_ctrl #(.CLK_BURST_LEN(CLK_BURST_LEN), .RAM_BURST_LEN(RAM_BURST_LEN)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_i    (ce_s),
        .rise_i  (pin_rise[1]),
        .fall_i  (pin_fall[1]),
        .din_i   (pin_lvl[0]),
        .rdata_i (reg_rdata),
        .we_o    (reg_we),
        .re_o    (reg_re),
        .space_o (reg_space),
        .addr_o  (reg_addr),
        .wdata_o (reg_wdata),
        .dout_o  (dio_out),
        .oe_o    (dio_oe),
        .cmd_o   (cmd_byte)
    );
endmodule

// File: rtl/s3w_slave_chk.sv
module s3w_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_s,
    input logic       reg_we,
    input logic       reg_re,
    input logic [4:0] reg_addr,
    input logic       dio_oe,
    input logic       cmd7
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> (!reg_we && !reg_re && !dio_oe));

    // R3
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R4
    we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> cmd7);

    // R5
    re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> (!reg_we && $past(!reg_re)));

    // R6
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re) |-> (reg_addr != 5'h1f));
endmodule

bind s3w_slave s3w_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_s     (ce_s),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .dio_oe   (dio_oe),
    .cmd7     (cmd_byte[7])
);

// File: tb/s3w_slave_tb.sv
module s3w_slave_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0, sclk = 1'b0, dio_in = 1'b0;
    logic       dio_out, dio_oe, reg_we, reg_re, reg_space;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata = 8'h00;

    int checks = 0, errors = 0, ce_low_cnt = 0;
    bit done = 1'b0;

    logic [7:0]  dev_mem [64];
    logic [7:0]  model   [64];
    logic [13:0] exp_wq [$];
    logic [5:0]  exp_rq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    s3w_slave u_dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .dio_in(dio_in),
        .dio_out(dio_out), .dio_oe(dio_oe), .reg_we(reg_we), .reg_re(reg_re),
        .reg_space(reg_space), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // register-file stand-in driven only by the bus ports
    always @(posedge clk) begin
        if (reg_we) dev_mem[{reg_space, reg_addr}] <= reg_wdata;
        if (reg_re) reg_rdata <= dev_mem[{reg_space, reg_addr}];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the expected strobe queues
    always @(negedge clk) begin
        if (rst_n) begin
            ce_low_cnt = ce ? 0 : ce_low_cnt + 1;
            if (ce_low_cnt > 4 && (reg_we || reg_re || dio_oe))
                chk(0, "R1/R7 quiet while enable low", {reg_we, reg_re, dio_oe}, 0);
            if (reg_we) begin
                if (exp_wq.size() == 0) chk(0, "R3/R4/R8 unexpected write", {reg_space, reg_addr, reg_wdata}, 0);
                else begin
                    logic [13:0] e;
                    e = exp_wq.pop_front();
                    chk({reg_space, reg_addr, reg_wdata} == e, "R3/R6 write strobe", {reg_space, reg_addr, reg_wdata}, e);
                end
            end
            if (reg_re) begin
                if (exp_rq.size() == 0) chk(0, "R5 unexpected read", {reg_space, reg_addr}, 0);
                else begin
                    logic [5:0] e;
                    e = exp_rq.pop_front();
                    chk({reg_space, reg_addr} == e, "R2/R5/R6 read strobe", {reg_space, reg_addr}, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] mkcmd(input logic wen, input logic ram, input logic [4:0] a, input logic rd);
        return {wen, ram, a, rd};
    endfunction

    task automatic send_bit(input logic b);
        dio_in = b; tick(4);
        sclk = 1'b1; tick(8);
        sclk = 1'b0; tick(4);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            tick(4);
            chk(dio_oe === 1'b1, "R5 data line driven", dio_oe, 1);
            v[i] = dio_out;
            sclk = 1'b1; tick(8);
            sclk = 1'b0; tick(4);
        end
    endtask

    task automatic start_xfer();
        ce = 1'b1; tick(4);
    endtask

    task automatic stop_xfer();
        tick(4); ce = 1'b0; tick(8);
    endtask

    task automatic wr_single(input logic wen, input logic ram, input logic [4:0] a, input logic [7:0] d);
        start_xfer();
        send_byte(mkcmd(wen, ram, a, 1'b0));
        if (wen) begin
            exp_wq.push_back({ram, a, d});
            model[{ram, a}] = d;
        end
        send_byte(d);
        send_byte(8'hFF);  // R3: trailing clocks, no further strobe
        stop_xfer();
    endtask

    task automatic rd_single(input logic wen, input logic ram, input logic [4:0] a, input string req);
        logic [7:0] v;
        exp_rq.push_back({ram, a});
        start_xfer();
        send_byte(mkcmd(wen, ram, a, 1'b1));
        recv_byte(v);
        chk(v == model[{ram, a}], req, v, model[{ram, a}]);
        stop_xfer();
    endtask

    task automatic burst_write(input logic ram);
        int n;
        n = ram ? 31 : 8;
        start_xfer();
        send_byte(mkcmd(1'b1, ram, 5'h1f, 1'b0));
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'(i * 11 + (ram ? 100 : 0) + 3);
            exp_wq.push_back({ram, 5'(i), d});
            model[{ram, 5'(i)}] = d;
            send_byte(d);
        end
        stop_xfer();
    endtask

    task automatic burst_read(input logic ram);
        int n;
        n = ram ? 31 : 8;
        for (int i = 0; i < n; i++) exp_rq.push_back({ram, 5'(i)});
        start_xfer();
        send_byte(mkcmd(1'b1, ram, 5'h1f, 1'b1));
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            recv_byte(v);
            chk(v == model[{ram, 5'(i)}], "R6 burst read byte", v, model[{ram, 5'(i)}]);
        end
        stop_xfer();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            dev_mem[i] = 8'(i * 37 + 5);
            model[i]   = 8'(i * 37 + 5);
        end
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1: reset state
        chk(!dio_oe && !reg_we && !reg_re, "R1 reset state", {dio_oe, reg_we, reg_re}, 0);

        // R2/R3: single writes and reads in both spaces
        wr_single(1'b1, 1'b1, 5'd5, 8'hA5);
        rd_single(1'b1, 1'b1, 5'd5, "R5 single RAM read");
        wr_single(1'b1, 1'b0, 5'd3, 8'h5A);
        rd_single(1'b1, 1'b0, 5'd3, "R2 clock space read");
        rd_single(1'b1, 1'b0, 5'd2, "R2 clock space untouched");
        rd_single(1'b1, 1'b1, 5'd30, "R2 top RAM address");

        // R4: write gated off, read still works
        wr_single(1'b0, 1'b1, 5'd6, 8'h3C);
        rd_single(1'b0, 1'b1, 5'd6, "R4 gated write left data");

        // R6: bursts in both spaces
        burst_write(1'b1);
        burst_read(1'b1);
        burst_write(1'b0);
        burst_read(1'b0);

        // R7: abort inside a write byte
        start_xfer();
        send_byte(mkcmd(1'b1, 1'b1, 5'd9, 1'b0));
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        ce = 1'b0; tick(8);
        chk(dio_oe == 1'b0, "R7 line released after write abort", dio_oe, 0);
        rd_single(1'b1, 1'b1, 5'd9, "R7 aborted write left data");

        // R7: abort inside a read byte
        exp_rq.push_back({1'b1, 5'd4});
        start_xfer();
        send_byte(mkcmd(1'b1, 1'b1, 5'd4, 1'b1));
        begin
            logic [7:0] d3;
            d3 = model[{1'b1, 5'd4}];
            for (int i = 0; i < 3; i++) begin
                tick(4);
                chk(dio_out == d3[i], "R7 partial read bit", dio_out, d3[i]);
                sclk = 1'b1; tick(8);
                sclk = 1'b0; tick(4);
            end
        end
        ce = 1'b0; tick(6);
        chk(dio_oe == 1'b0, "R7 line released after read abort", dio_oe, 0);
        tick(4);

        // R8: enable drop together with the byte-completing edge
        start_xfer();
        send_byte(mkcmd(1'b1, 1'b1, 5'd10, 1'b0));
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        dio_in = 1'b0; tick(4);
        sclk = 1'b1; ce = 1'b0; tick(8);
        sclk = 1'b0; tick(8);
        rd_single(1'b1, 1'b1, 5'd10, "R8 abort beat completing edge");

        tick(10);
        chk(exp_wq.size() == 0, "R3/R6 all writes seen", exp_wq.size(), 0);
        chk(exp_rq.size() == 0, "R5/R6 all reads seen", exp_rq.size(), 0);
        finish_run();
    end
endmodule